// File: doc/BRIEF.md
# Two-Port Pin Direction and Level Controller

This block lets software drive and sample a bank of general-purpose pins through four registers on a simple register bus. The pins form two ports. The wide port has sixteen pins and the narrow port has four. For each port, one register holds a two-bit mode per pin. A second register holds the level that pins configured as outputs should drive.

The mode decides, pin by pin, whether the pin drives, listens or does neither. The block turns the stored modes into an output-enable bus and a driven-level bus. Reading a level register returns one merged view: sampled external levels on listening pins, and the levels being driven on driving pins. External levels pass through a two-stage synchronizer before they reach the read path.

Register offsets (word addresses): 0 = wide-port mode, 1 = wide-port level, 2 = narrow-port mode, 3 = narrow-port level.

Top module: `pin_bank_ctl`

## Requirements
- R1: After reset, both mode registers and both level registers read 0, and `pin_oe` and `pin_out` are all 0.
- R2: The mode of pin i of a port is held in bits [2i+1:2i] of that port's mode register, and a mode register reads back the value last written to it.
- R3: A mode value of 2'b10 makes a pin a listener, 2'b01 or 2'b11 makes it a driver, and 2'b00 makes it neither. `pin_oe` for a pin is 1 exactly when the pin is a driver.
- R4: A level-register write changes `pin_out` only on pins that are drivers. All other pins drive 0.
- R5: A mode-register write re-applies the stored level value through the new driver set, with no new level write needed.
- R6: A level-register read returns the synchronized external input ANDed with the listener mask, ORed with the port's currently driven bits.
- R7: The wide port uses bits 15:0 of `pin_in`, `pin_out` and `pin_oe`, and the narrow port uses bits 19:16. Writing one port's registers leaves the other port's bits unchanged.
- R8: Addresses 4 and up read as 0, and writes to them change no register or output.
- R9: A change on `pin_in` becomes visible in a level read after exactly two rising clock edges, not after one.
- R10: Register writes take effect on the rising clock edge where `bus_we` is high. Reads are combinational from `bus_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pin_in | input | 20 | External pin levels (asynchronous) |
| pin_out | output | 20 | Driven pin levels |
| pin_oe | output | 20 | Per-pin output enable |

## Verification
The hardest case is a mode rewrite that turns pins into drivers after the level register was written while they were not drivers. The level must come out without a fresh level write. The bench first writes all-ones levels while only two pins drive, then checks that only those two pins drive high. It then rewrites the mode alone and checks that all sixteen pins now drive the stored ones. Synchronizer latency is checked by sampling the merged read between the first and second clock edge after an input change.

// File: rtl/pin_bank_pkg.sv
package pin_bank_pkg;
    localparam logic [1:0] MODE_NONE   = 2'b00;
    localparam logic [1:0] MODE_LISTEN = 2'b10;

    localparam int REG_MODE_W  = 0;
    localparam int REG_LEVEL_W = 1;
    localparam int REG_MODE_N  = 2;
    localparam int REG_LEVEL_N = 3;
endpackage

// File: rtl/pin_sync2.sv
module pin_sync2 #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] st1;
        logic [W-1:0] st2;
        logic [1:0]   age;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d     = sync_q;
        sync_d.st1 = raw_in;
        sync_d.st2 = sync_q.st1;
        if (sync_q.age != 2'd3) sync_d.age = sync_q.age + 2'd1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign sync_out = sync_q.st2;

    // R9
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_q.age >= 2'd2) |-> (sync_out == $past(raw_in, 2)));
endmodule

// File: rtl/pin_lane.sv
module pin_lane
    import pin_bank_pkg::*;
#(
    parameter int PINS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic              level_we,
    input  logic [2*PINS-1:0] mode_wdata,
    input  logic [PINS-1:0]   level_wdata,
    input  logic [PINS-1:0]   smp_in,
    output logic [PINS-1:0]   drive,
    output logic [PINS-1:0]   oe,
    output logic [2*PINS-1:0] mode_rd,
    output logic [PINS-1:0]   level_rd
);
    localparam int MW = 2 * PINS;

    typedef struct packed {
        logic [MW-1:0]   mode;
        logic [PINS-1:0] level;
    } lane_t;

    lane_t lane_d, lane_q;
    logic [PINS-1:0] listen_mask;
    logic [PINS-1:0] drive_mask;

    function automatic logic [PINS-1:0] drivers_of(input logic [MW-1:0] m);
        logic [PINS-1:0] r;
        for (int k = 0; k < PINS; k++) r[k] = m[2*k];
        return r;
    endfunction

    generate
        for (genvar i = 0; i < PINS; i++) begin : g_pin
            assign listen_mask[i] = (lane_q.mode[2*i+1:2*i] == MODE_LISTEN);
            assign drive_mask[i]  = (lane_q.mode[2*i+1:2*i] != MODE_NONE) &&
                                    (lane_q.mode[2*i+1:2*i] != MODE_LISTEN);
        end
    endgenerate

    always_comb begin
        lane_d = lane_q;
        if (mode_we)  lane_d.mode  = mode_wdata;
        if (level_we) lane_d.level = level_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lane_q <= '0;
        else        lane_q <= lane_d;
    end

    assign drive    = lane_q.level & drive_mask;
    assign oe       = drive_mask;
    assign mode_rd  = lane_q.mode;
    assign level_rd = (smp_in & listen_mask) | drive;

    // R4
    level_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level_we && !mode_we) |=> (drive == ($past(level_wdata) & oe)));

    // R3
    oe_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we |=> (oe == drivers_of($past(mode_wdata))));

    // R7
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_we && !level_we) |=> ($stable(drive) && $stable(oe)));
endmodule

// File: rtl/pin_bank_ctl.sv
module pin_bank_ctl
    import pin_bank_pkg::*;
#(
    parameter int W_PINS = 16,
    parameter int N_PINS = 4,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_we,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    input  logic [W_PINS+N_PINS-1:0]   pin_in,
    output logic [W_PINS+N_PINS-1:0]   pin_out,
    output logic [W_PINS+N_PINS-1:0]   pin_oe
);
    localparam int TOT = W_PINS + N_PINS;

    logic [TOT-1:0]      pin_sync;
    logic                we_mode_w, we_level_w, we_mode_n, we_level_n;
    logic [2*W_PINS-1:0] mode_w_rd;
    logic [2*N_PINS-1:0] mode_n_rd;
    logic [W_PINS-1:0]   level_w_rd, drive_w, oe_w;
    logic [N_PINS-1:0]   level_n_rd, drive_n, oe_n;

    assign we_mode_w  = bus_we && (bus_addr == ADDR_W'(REG_MODE_W));
    assign we_level_w = bus_we && (bus_addr == ADDR_W'(REG_LEVEL_W));
    assign we_mode_n  = bus_we && (bus_addr == ADDR_W'(REG_MODE_N));
    assign we_level_n = bus_we && (bus_addr == ADDR_W'(REG_LEVEL_N));

    pin_sync2 #(.W(TOT)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_in(pin_in), .sync_out(pin_sync)
    );

    pin_lane #(.PINS(W_PINS)) u_wide (
        .clk(clk), .rst_n(rst_n),
        .mode_we(we_mode_w), .level_we(we_level_w),
        .mode_wdata(bus_wdata[2*W_PINS-1:0]),
        .level_wdata(bus_wdata[W_PINS-1:0]),
        .smp_in(pin_sync[W_PINS-1:0]),
        .drive(drive_w), .oe(oe_w),
        .mode_rd(mode_w_rd), .level_rd(level_w_rd)
    );

    pin_lane #(.PINS(N_PINS)) u_narrow (
        .clk(clk), .rst_n(rst_n),
        .mode_we(we_mode_n), .level_we(we_level_n),
        .mode_wdata(bus_wdata[2*N_PINS-1:0]),
        .level_wdata(bus_wdata[N_PINS-1:0]),
        .smp_in(pin_sync[TOT-1:W_PINS]),
        .drive(drive_n), .oe(oe_n),
        .mode_rd(mode_n_rd), .level_rd(level_n_rd)
    );

    assign pin_out = {drive_n, drive_w};
    assign pin_oe  = {oe_n, oe_w};

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(REG_MODE_W):  bus_rdata = DATA_W'(mode_w_rd);
            ADDR_W'(REG_LEVEL_W): bus_rdata = DATA_W'(level_w_rd);
            ADDR_W'(REG_MODE_N):  bus_rdata = DATA_W'(mode_n_rd);
            ADDR_W'(REG_LEVEL_N): bus_rdata = DATA_W'(level_n_rd);
            default:              bus_rdata = '0;
        endcase
    end

    // R8
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr > ADDR_W'(REG_LEVEL_N)) |-> (bus_rdata == '0));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (pin_oe == '0 && pin_out == '0));
endmodule

// File: tb/sim_pin_bank_ctl.sv
module sim_pin_bank_ctl;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [3:0]  bus_addr = 0;
    logic        bus_we = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic [19:0] pin_in = 0;
    logic [19:0] pin_out, pin_oe;

    int errors = 0, checks = 0;
    bit done = 0;

    logic [31:0] ma = 0;
    logic [7:0]  mb = 0;
    logic [15:0] la = 0;
    logic [3:0]  lb = 0;

    pin_bank_ctl u0 (.*);

    always #10 clk = ~clk;

    function automatic logic [19:0] m_oe();
        logic [19:0] r;
        for (int i = 0; i < 16; i++) r[i] = ma[2*i];
        for (int i = 0; i < 4; i++)  r[16+i] = mb[2*i];
        return r;
    endfunction

    function automatic logic [19:0] m_drv();
        return {lb, la} & m_oe();
    endfunction

    function automatic logic [15:0] m_rd_a();
        logic [15:0] im;
        for (int i = 0; i < 16; i++) im[i] = (ma[2*i+1 -: 2] == 2'b10);
        return (pin_in[15:0] & im) | m_drv()[15:0];
    endfunction

    function automatic logic [3:0] m_rd_b();
        logic [3:0] im;
        for (int i = 0; i < 4; i++) im[i] = (mb[2*i+1 -: 2] == 2'b10);
        return (pin_in[19:16] & im) | m_drv()[19:16];
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1; bus_wdata = d;
        @(negedge clk);
        bus_we = 0;
        case (a)
            4'd0: ma = d;
            4'd1: la = d[15:0];
            4'd2: mb = d[7:0];
            4'd3: lb = d[3:0];
            default: ;
        endcase
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(4'(a), v); check("R1 reg after reset", v, 0);
        end
        check("R1 oe after reset", 32'(pin_oe), 0);
        check("R1 out after reset", 32'(pin_out), 0);
    endtask

    task automatic t_field_pos();
        logic [31:0] v;
        wr(4'd0, 32'h0000_0040);          // pin 3 mode 01
        check("R2 pin3 field", 32'(pin_oe), 32'h8);
        rd(4'd0, v); check("R2 mode readback", v, 32'h0000_0040);
    endtask

    task automatic t_encoding();
        wr(4'd0, 32'h0000_002D);          // p0=01 p1=11 p2=10 p3=00
        check("R3 decode oe", 32'(pin_oe), 32'h3);
    endtask

    task automatic t_data_mask();
        wr(4'd1, 32'h0000_FFFF);
        check("R4 drive only drivers", 32'(pin_out), 32'(m_drv()));
        check("R4 drive exact", 32'(pin_out), 32'h3);
    endtask

    task automatic t_remap();
        wr(4'd0, 32'h5555_5555);
        check("R5 remap drive", 32'(pin_out), 32'h0000_FFFF);
        check("R5 remap oe", 32'(pin_oe), 32'h0000_FFFF);
    endtask

    task automatic t_read_merge();
        logic [31:0] v;
        wr(4'd0, 32'h0000_A96D);          // mix of listeners, drivers, unused
        wr(4'd1, 32'h0000_00F0);
        @(negedge clk); pin_in[15:0] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rd(4'd1, v); check("R6 merged read", v, 32'(m_rd_a()));
        pin_in[15:0] = 16'h0000;
        repeat (3) @(negedge clk);
        rd(4'd1, v); check("R6 merged read low", v, 32'(m_rd_a()));
    endtask

    task automatic t_port_b();
        logic [19:0] before_out, before_oe;
        logic [31:0] v;
        before_out = pin_out; before_oe = pin_oe;
        wr(4'd2, 32'h0000_0087);          // p0=11 p1=01 p2=00 p3=10
        wr(4'd3, 32'h0000_000F);
        check("R7 narrow oe", 32'(pin_oe[19:16]), 32'h3);
        check("R7 narrow out", 32'(pin_out[19:16]), 32'h3);
        check("R7 wide untouched out", 32'(pin_out[15:0]), 32'(before_out[15:0]));
        check("R7 wide untouched oe", 32'(pin_oe[15:0]), 32'(before_oe[15:0]));
        pin_in[19] = 1;
        repeat (3) @(negedge clk);
        rd(4'd3, v); check("R7 narrow read", v, 32'(m_rd_b()));
        before_out = pin_out;
        wr(4'd1, 32'h0000_0000);
        check("R7 narrow kept", 32'(pin_out[19:16]), 32'(before_out[19:16]));
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        logic [19:0] o, e;
        o = pin_out; e = pin_oe;
        wr(4'd7, 32'hFFFF_FFFF);
        wr(4'd4, 32'hFFFF_FFFF);
        rd(4'd5, v); check("R8 unmapped read", v, 0);
        check("R8 no out change", 32'(pin_out), 32'(o));
        check("R8 no oe change", 32'(pin_oe), 32'(e));
        rd(4'd0, v); check("R8 mode kept", v, ma);
    endtask

    task automatic t_sync();
        logic [31:0] v;
        wr(4'd0, 32'h0000_0020);          // pin 2 listener
        @(negedge clk); pin_in[2] = 1;
        @(negedge clk);                   // one edge passed
        rd(4'd1, v); check("R9 not after one edge", v & 32'h4, 0);
        @(negedge clk);                   // two edges passed
        rd(4'd1, v); check("R9 after two edges", v & 32'h4, 32'h4);
    endtask

    task automatic t_timing();
        @(negedge clk);
        bus_addr = 4'd3; bus_wdata = 32'h0; bus_we = 1;
        #1; check("R10 before edge", 32'(pin_out[19:16]), 32'(m_drv()[19:16]));
        @(negedge clk); bus_we = 0; lb = 0;
        check("R10 after edge", 32'(pin_out[19:16]), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_field_pos();
        t_encoding();
        t_data_mask();
        t_remap();
        t_read_merge();
        t_port_b();
        t_unmapped();
        t_sync();
        t_timing();
        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule